// File: doc/BRIEF.md
# Block Address Translation Matcher

This block keeps two small banks of block translation entries, one consulted by instruction fetches and one by loads and stores. Each entry is a pair of 32-bit words. The upper word names the effective block base, its length and the privilege modes in which the entry is live. The lower word gives the real block base and a two-bit protection code. A lookup presents an effective address, the access class (fetch or data) and the privilege mode. In the same cycle the block reports whether any live entry covers the address. On a hit it also reports which entry won, the page-aligned real address, and the read, write and execute rights that entry grants.

Entries are loaded one word at a time through a synchronous write port, and a write becomes visible to lookups on the following cycle. The block raises no faults. A separate checker compares the granted rights with the access type and decides the outcome.

Upper word layout: bits [31:17] hold the effective block base, bits [12:2] hold the length field, bit 1 enables the entry in supervisor mode, and bit 0 enables it in user mode. Lower word layout: bits [31:17] hold the real block base and bits [1:0] hold the protection code. All other bits are ignored.

Top module: `bat_matcher`

## Requirements
- R1: After reset every entry of both banks reads as zero, so every lookup misses until an entry is written.
- R2: An entry takes part in a lookup only when upper bit 1 is set during a supervisor lookup (lk_user=0), or upper bit 0 is set during a user lookup (lk_user=1).
- R3: The compare mask is 0xFFFE0000 with the length field upper[12:2] cleared out of mask bits [27:17]. A length value with its low k bits set therefore covers 128 KiB times 2^k.
- R4: A live entry hits when the effective address ANDed with its mask equals upper[31:17] followed by 17 zero bits. A base bit set inside the length-cleared region therefore prevents any hit.
- R5: On a hit, real_addr takes the mask-selected bits from the lower word and the remaining bits from the effective address. Bits [11:0] of real_addr are forced to zero.
- R6: Protection code lower[1:0]=0 grants no rights. Any nonzero code grants read and execute, and code 2 also grants write.
- R7: When several live entries hit, the one with the lowest index wins, and its index appears on hit_idx.
- R8: A fetch lookup (lk_fetch=1) uses only the instruction bank, and a data lookup (lk_fetch=0) uses only the data bank.
- R9: Lookups are combinational. A word written on a clock edge is seen by lookups only after that edge. Writes whose index is at or beyond the entry count change nothing.
- R10: On a miss, hit is 0 and hit_idx, real_addr and all three rights outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry word this cycle |
| wr_bank | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx | input | 2 | Entry index to write |
| wr_upper | input | 1 | 1 = upper word, 0 = lower word |
| wr_data | input | 32 | Word to store |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_user | input | 1 | Lookup is in user mode |
| lk_ea | input | 32 | Effective address to translate |
| hit | output | 1 | A live entry covers the address |
| hit_idx | output | 2 | Index of the winning entry |
| real_addr | output | 32 | Page-aligned real address |
| rd_ok | output | 1 | Winning entry grants read |
| wr_ok | output | 1 | Winning entry grants write |
| ex_ok | output | 1 | Winning entry grants execute |

## Verification
The assertions check on every cycle that a matching entry was live for the current mode, that the winner is a matching entry with no lower-index match, and that a stored word equals the data written one cycle earlier. They also check that the real address is page aligned, that misses are silent, and that write rights always come with read rights. Only the bench scenarios can show that the mask arithmetic, the address splice, the bank choice and the protection decode produce the right values. The same holds for a write in the same cycle as a lookup of that entry, which must still see the old contents.

// File: rtl/bat_pkg.sv
package bat_pkg;
    localparam int ADDR_W      = 32;
    localparam int PAGE_BITS   = 12;
    localparam int BASE_LSB    = 17;
    localparam int LEN_LSB     = 2;
    localparam int LEN_W       = 11;
    localparam int SUP_BIT     = 1;
    localparam int USR_BIT     = 0;
    localparam int PROT_W      = 2;
    localparam logic [ADDR_W-1:0] BASE_FIELD = ~((ADDR_W'(1) << BASE_LSB) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] PAGE_KEEP  = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));
    localparam logic [PROT_W-1:0] PROT_NONE  = 2'd0;
    localparam logic [PROT_W-1:0] PROT_RW    = 2'd2;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;
endpackage

// File: rtl/bat_regbank.sv
module bat_regbank
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic                                wr_bank,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic                                wr_upper,
    input  logic [ADDR_W-1:0]                   wr_data,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  ins_up,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  ins_lo,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  dat_up,
    output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]  dat_lo
);
    typedef struct packed {
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] iu;
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] il;
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] du;
        logic [NUM_ENTRIES-1:0][ADDR_W-1:0] dl;
    } store_t;

    store_t st_d, st_q;
    logic   idx_ok;

    assign idx_ok = (32'(wr_idx) < NUM_ENTRIES);

    always_comb begin
        st_d = st_q;
        if (wr_en && idx_ok) begin
            case ({wr_bank, wr_upper})
                2'b11:   st_d.iu[wr_idx] = wr_data;
                2'b10:   st_d.il[wr_idx] = wr_data;
                2'b01:   st_d.du[wr_idx] = wr_data;
                default: st_d.dl[wr_idx] = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ins_up = st_q.iu;
    assign ins_lo = st_q.il;
    assign dat_up = st_q.du;
    assign dat_lo = st_q.dl;

    function automatic logic [ADDR_W-1:0] pick(input store_t s, input logic b,
                                               input logic u, input logic [IDX_W-1:0] i);
        logic [ADDR_W-1:0] w;
        w = '0;
        if (32'(i) < NUM_ENTRIES) begin
            case ({b, u})
                2'b11:   w = s.iu[i];
                2'b10:   w = s.il[i];
                2'b01:   w = s.du[i];
                default: w = s.dl[i];
            endcase
        end
        return w;
    endfunction

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_ok) |=> (pick(st_q, $past(wr_bank), $past(wr_upper), $past(wr_idx)) == $past(wr_data))) // R9
        else $error("write did not land");
endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
    import bat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] upper,
    input  logic [ADDR_W-1:0] lower,
    input  logic [ADDR_W-1:0] ea,
    input  logic              user,
    output logic              match,
    output logic [ADDR_W-1:0] paddr,
    output rights_t           rights
);
    logic              live;
    logic [ADDR_W-1:0] len_cut;
    logic [ADDR_W-1:0] mask;
    logic [PROT_W-1:0] prot;

    always_comb begin
        live    = user ? upper[USR_BIT] : upper[SUP_BIT];
        len_cut = ADDR_W'(upper[LEN_LSB +: LEN_W]) << BASE_LSB;
        mask    = BASE_FIELD & ~len_cut;
        match   = live && ((ea & mask) == (upper & BASE_FIELD));
        paddr   = ((lower & mask) | (ea & ~mask)) & PAGE_KEEP;
        prot    = lower[PROT_W-1:0];
        rights.rd = (prot != PROT_NONE);
        rights.ex = (prot != PROT_NONE);
        rights.wr = (prot == PROT_RW);
    end

    AST_MATCH_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (user ? upper[USR_BIT] : upper[SUP_BIT])) // R2
        else $error("match without live bit");
endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_ENTRIES-1:0]             match,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] paddr,
    input  rights_t [NUM_ENTRIES-1:0]          rights,
    output logic                               hit,
    output logic [IDX_W-1:0]                   idx,
    output logic [ADDR_W-1:0]                  sel_addr,
    output rights_t                            sel_rights
);
    always_comb begin
        hit        = 1'b0;
        idx        = '0;
        sel_addr   = '0;
        sel_rights = '0;
        for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit        = 1'b1;
                idx        = IDX_W'(k);
                sel_addr   = paddr[k];
                sel_rights = rights[k];
            end
        end
    end

    AST_WINNER_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match[idx]) // R7
        else $error("winner does not match");
    AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match & ((NUM_ENTRIES'(1) << idx) - NUM_ENTRIES'(1))) == '0)) // R7
        else $error("lower index also matched");
    AST_ANY_MATCH_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (match != '0) |-> hit) // R4
        else $error("match lost");
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
    import bat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_upper,
    input  logic [31:0]       wr_data,
    input  logic              lk_fetch,
    input  logic              lk_user,
    input  logic [31:0]       lk_ea,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [31:0]       real_addr,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              ex_ok
);
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ins_up, ins_lo, dat_up, dat_lo;
    logic [NUM_ENTRIES-1:0]             match;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] paddr;
    rights_t [NUM_ENTRIES-1:0]          rights;
    rights_t                            sel_rights;

    bat_regbank #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_upper(wr_upper),
        .wr_data (wr_data),
        .ins_up  (ins_up),
        .ins_lo  (ins_lo),
        .dat_up  (dat_up),
        .dat_lo  (dat_lo)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        logic [ADDR_W-1:0] up_w, lo_w;
        assign up_w = lk_fetch ? ins_up[g] : dat_up[g];
        assign lo_w = lk_fetch ? ins_lo[g] : dat_lo[g];
        bat_entry_cmp u_cmp (
            .clk   (clk),
            .rst_n (rst_n),
            .upper (up_w),
            .lower (lo_w),
            .ea    (lk_ea),
            .user  (lk_user),
            .match (match[g]),
            .paddr (paddr[g]),
            .rights(rights[g])
        );
    end

    bat_prio_sel #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .paddr     (paddr),
        .rights    (rights),
        .hit       (hit),
        .idx       (hit_idx),
        .sel_addr  (real_addr),
        .sel_rights(sel_rights)
    );

    assign rd_ok = sel_rights.rd;
    assign wr_ok = sel_rights.wr;
    assign ex_ok = sel_rights.ex;

    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        real_addr[PAGE_BITS-1:0] == '0) // R5
        else $error("real address not page aligned");
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0 && real_addr == '0 && !rd_ok && !wr_ok && !ex_ok)) // R10
        else $error("miss drives outputs");
    AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> (rd_ok && ex_ok)) // R6
        else $error("write without read");
    AST_EXEC_TRACKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ex_ok == rd_ok) // R6
        else $error("execute differs from read");
endmodule

// File: tb/tb_bat_matcher.sv
`timescale 1ns/1ps
module tb_bat_matcher;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_bank = 1'b0, wr_upper = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        lk_fetch = 1'b0, lk_user = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        hit, rd_ok, wr_ok, ex_ok;
    logic [1:0]  hit_idx;
    logic [31:0] real_addr;

    always #4 clk = ~clk;

    bat_matcher dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
        .wr_upper(wr_upper), .wr_data(wr_data), .lk_fetch(lk_fetch), .lk_user(lk_user),
        .lk_ea(lk_ea), .hit(hit), .hit_idx(hit_idx), .real_addr(real_addr),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .ex_ok(ex_ok)
    );

    typedef struct {
        logic        h;
        logic [1:0]  i;
        logic [31:0] a;
        logic        r, w, x;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] m_iu[N], m_il[N], m_du[N], m_dl[N];
    int          checks = 0, fails = 0;
    bit          done = 0;

    function automatic exp_t predict(logic f, logic u, logic [31:0] ea, string tag);
        exp_t e;
        e.h = 0; e.i = 0; e.a = 0; e.r = 0; e.w = 0; e.x = 0; e.tag = tag;
        for (int k = 0; k < N; k++) begin
            logic [31:0] up, lo, mk;
            logic        lv;
            up = f ? m_iu[k] : m_du[k];
            lo = f ? m_il[k] : m_dl[k];
            lv = u ? up[0] : up[1];
            mk = 32'hFFFE0000 & ~(32'(up[12:2]) << 17);
            if (!e.h && lv && ((ea & mk) == (up & 32'hFFFE0000))) begin
                e.h = 1;
                e.i = 2'(k);
                e.a = ((lo & mk) | (ea & ~mk)) & 32'hFFFFF000;
                e.r = (lo[1:0] != 0);
                e.x = (lo[1:0] != 0);
                e.w = (lo[1:0] == 2);
            end
        end
        return e;
    endfunction

    task automatic cyc(input logic we, input logic wb, input int wi, input logic wu,
                       input logic [31:0] wd, input logic f, input logic u,
                       input logic [31:0] ea, input string tag);
        @(negedge clk);
        wr_en = we; wr_bank = wb; wr_idx = 2'(wi); wr_upper = wu; wr_data = wd;
        lk_fetch = f; lk_user = u; lk_ea = ea;
        sb.push_back(predict(f, u, ea, tag));
        if (we && wi < N) begin
            case ({wb, wu})
                2'b11: m_iu[wi] = wd;
                2'b10: m_il[wi] = wd;
                2'b01: m_du[wi] = wd;
                default: m_dl[wi] = wd;
            endcase
        end
    endtask

    task automatic wr(input logic wb, input int wi, input logic wu, input logic [31:0] wd);
        cyc(1, wb, wi, wu, wd, 0, 0, 32'h0, "R9 write cycle");
    endtask

    task automatic look(input logic f, input logic u, input logic [31:0] ea, input string tag);
        cyc(0, 0, 0, 0, 32'h0, f, u, ea, tag);
    endtask

    always @(negedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (hit !== e.h || hit_idx !== e.i || real_addr !== e.a ||
                rd_ok !== e.r || wr_ok !== e.w || ex_ok !== e.x) begin
                fails++;
                $display("FAIL %s: got hit=%b idx=%0d pa=%h rwx=%b%b%b, expected hit=%b idx=%0d pa=%h rwx=%b%b%b",
                         e.tag, hit, hit_idx, real_addr, rd_ok, wr_ok, ex_ok,
                         e.h, e.i, e.a, e.r, e.w, e.x);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) begin
            m_iu[k] = 0; m_il[k] = 0; m_du[k] = 0; m_dl[k] = 0;
        end
        look(0, 0, 32'h1001_2345, "R1 miss during reset");
        @(negedge clk); rst_n = 1'b1;
        look(1, 1, 32'h0000_0000, "R1 fetch miss after reset");
        look(0, 0, 32'hFFFF_F000, "R1 data miss after reset R10");

        // data entry 0: 128 KiB at 0x10000000, supervisor only, read/write
        wr(0, 0, 1, 32'h1000_0002);
        wr(0, 0, 0, 32'h8000_0002);
        look(0, 0, 32'h1001_2345, "R4 R5 R6 supervisor data hit");
        look(0, 1, 32'h1001_2345, "R2 user blocked by supervisor-only entry");
        look(1, 0, 32'h1001_2345, "R8 fetch ignores data bank");
        look(0, 0, 32'h1002_0000, "R3 just past 128 KiB block");

        // data entry 1: 2 MiB at 0x20000000, user only, read-only
        wr(0, 1, 1, 32'h2000_003D);
        wr(0, 1, 0, 32'h401E_0001);
        look(0, 1, 32'h201A_B678, "R3 R5 user hit in 2 MiB block");
        look(0, 0, 32'h201A_B678, "R2 supervisor blocked by user-only entry");
        look(0, 1, 32'h2020_0000, "R3 just past 2 MiB block");

        // instruction bank: two overlapping entries
        wr(1, 0, 1, 32'h1000_0003);
        wr(1, 0, 0, 32'hC000_0003);
        wr(1, 1, 1, 32'h1000_0003);
        wr(1, 1, 0, 32'hE000_0002);
        look(1, 0, 32'h1000_0ABC, "R7 R8 fetch picks index 0");
        look(1, 1, 32'h1001_FFFF, "R6 code 3 grants read/exec only");

        // data entry 2 overlaps entry 0; entry 3 has no rights
        wr(0, 2, 1, 32'h1000_0002);
        wr(0, 2, 0, 32'h9000_0001);
        look(0, 0, 32'h1000_4000, "R7 lower index wins over entry 2");
        wr(0, 3, 1, 32'h3000_0002);
        wr(0, 3, 0, 32'h7000_0000);
        look(0, 0, 32'h3000_1000, "R6 code 0 hit grants nothing");

        // same-cycle write and lookup of entry 0
        cyc(1, 0, 0, 1, 32'h0000_0000, 0, 0, 32'h1000_4000, "R9 lookup sees old entry in write cycle");
        look(0, 0, 32'h1000_4000, "R7 R9 entry 2 wins after entry 0 cleared");

        // base bit inside length-cleared region never matches
        wr(0, 1, 1, 32'h5002_0006);
        look(0, 0, 32'h5002_0000, "R4 base bit in length region blocks hit");
        look(0, 0, 32'h5000_0000, "R4 R10 miss at block start");

        // out-of-range index never happens with 4 entries; a miss elsewhere
        look(1, 0, 32'h2000_0000, "R8 R10 fetch miss on data-only region");

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule